// File: doc/BRIEF.md
# Segmented-Memory Accumulator CPU with Single-Level Subroutine Call

This block is a small 8-bit accumulator processor with a 512-byte internal RAM. A ninth address bit, driven by the microcode, splits the RAM into two halves. The low half (bit 8 clear) holds code and is used for every opcode fetch, every operand fetch and every jump target. The high half (bit 8 set) holds data and is used for every data read and every data write. Instructions that carry an operand take two bytes: the opcode, then the operand.

All transfers go through one internal bus, and each microstep of an instruction picks one driver for that bus. Data bytes 1 to 7 serve as virtual registers. An instruction names one of them with the low three bits of its opcode, and that field is placed on the bus to address the slot. A subroutine call saves its return address in data byte 0, so calls cannot nest.

A program is loaded through a write port. While the load enable is high, the core is held at its start state and each byte on the port is written to RAM. When the load enable falls, the core starts executing at code address 0.

Top module: `seg_cpu`

## Requirements
- R1: After reset, and during any cycle with the load enable high, `halted` and `out_valid` are 0 and `out_data` is 0. When the load enable is released, execution starts at code address 0.
- R2: RAM addresses are 9 bits wide and bit 8 selects the segment. Opcode fetches, operand fetches and jump targets all use bit 8 = 0 (code addresses 0–255).
- R3: Every data read and data write issued by an instruction uses bit 8 = 1 (data addresses 256–511).
- R4: Opcode 0x06 loads the next byte into the accumulator. Opcode 0x0E copies the accumulator to `out_data` and raises `out_valid` for exactly one cycle.
- R5: Opcode 0x08 reads the data byte whose offset is the operand into the accumulator. The program counter advances past both bytes of the instruction.
- R6: Opcodes 0x10–0x17 (binary 00010rrr) write the immediate byte into data byte rrr.
- R7: Opcodes 0x0B–0x0D (binary 00001rrr, rrr = 3..5) copy the data byte at the operand offset into data byte rrr. The temporary register is used for the transfer.
- R8: Opcode 0x09 (call) stores the address that follows its operand into data byte 0, then jumps to the code address given by the operand.
- R9: Opcode 0x0A (return) loads the program counter from data byte 0.
- R10: Opcode 0x01 jumps to the code address given by its operand.
- R11: Opcode 0x0F sets `halted`. While halted, the program counter and the step counter stay frozen and no output is produced until the next load.
- R12: The number of clock cycles each instruction takes is fixed: 3 for opcodes with no defined meaning, 0x0E and 0x0F; 4 for 0x06, 0x01 and 0x0A; 5 for 0x08; 6 for 00010rrr; 7 for 0x09 and 0x0B–0x0D. The step counter never exceeds 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Active-low reset |
| load_en | input | 1 | Holds the core at its start state and gives the RAM to the load port |
| load_we | input | 1 | Write strobe for the load port |
| load_addr | input | 9 | Load address; bit 8 selects the segment |
| load_data | input | 8 | Byte to be written through the load port |
| out_data | output | 8 | Last value written by the output instruction |
| out_valid | output | 1 | One-cycle pulse when `out_data` is updated |
| halted | output | 1 | High once the halt instruction has executed |

## Verification
The bench builds the block with its default 8-bit word, a 3-bit step counter and a 3-bit register selector. This is small enough to sweep every virtual register slot with the load-immediate instruction and every operand-copy slot with the memory-to-register instruction. It also sweeps the accumulator immediate over its edge values and data-load offsets at both ends of the data segment. Before each run, the code segment is filled with halt opcodes and planted bytes are placed at the matching offset in the wrong segment, so any mix-up between segments changes the visible output. The cycle of each output pulse is predicted by adding up the instruction lengths, which checks both timing and call/return flow.

// File: rtl/seg_cpu_pkg.sv
package seg_cpu_pkg;

  // Which unit drives the shared bus in a microstep.
  typedef enum logic [2:0] {
    BUS_NONE = 3'd0,
    BUS_RAM  = 3'd1,
    BUS_PC   = 3'd2,
    BUS_ACC  = 3'd3,
    BUS_TEMP = 3'd4,
    BUS_SLOT = 3'd5
  } bus_src_e;

  typedef enum logic [3:0] {
    OPC_NOP,
    OPC_LDI_ACC,
    OPC_JMP,
    OPC_LD_ACC,
    OPC_LD_SLOT,
    OPC_CALL,
    OPC_RET,
    OPC_LDI_SLOT,
    OPC_OUT,
    OPC_HALT
  } op_class_e;

  // One microstep's control word.
  typedef struct packed {
    bus_src_e src;
    logic     mar_ld;
    logic     ir_ld;
    logic     acc_ld;
    logic     tmp_ld;
    logic     ram_wr;
    logic     pc_ld;
    logic     pc_inc;
    logic     out_ld;
    logic     halt;
    logic     data_seg;
    logic     step_clr;
  } ctl_t;

  function automatic op_class_e classify(input logic [7:0] op);
    op_class_e c;
    c = OPC_NOP;
    if (op[7:3] == 5'b00010) c = OPC_LDI_SLOT;
    else begin
      case (op)
        8'h01: c = OPC_JMP;
        8'h06: c = OPC_LDI_ACC;
        8'h08: c = OPC_LD_ACC;
        8'h09: c = OPC_CALL;
        8'h0A: c = OPC_RET;
        8'h0B, 8'h0C, 8'h0D: c = OPC_LD_SLOT;
        8'h0E: c = OPC_OUT;
        8'h0F: c = OPC_HALT;
        default: c = OPC_NOP;
      endcase
    end
    return c;
  endfunction

  // Segment bit in front of an in-segment offset.
  function automatic logic [8:0] seg_join(input logic seg, input logic [7:0] off);
    return {seg, off};
  endfunction

endpackage

// File: rtl/seg_cpu_useq.sv
module seg_cpu_useq
  import seg_cpu_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic [7:0]        opcode,
  input  logic [STEP_W-1:0] step,
  output ctl_t              ctl
);

  op_class_e cls;
  int        s;

  assign cls = classify(opcode);
  assign s   = int'(step);

  always_comb begin
    ctl = '0;
    if (s == 0) begin
      ctl.src = BUS_PC;  ctl.mar_ld = 1'b1;
    end else if (s == 1) begin
      ctl.src = BUS_RAM; ctl.ir_ld = 1'b1; ctl.pc_inc = 1'b1;
    end else begin
      case (cls)
        OPC_NOP: ctl.step_clr = 1'b1;
        OPC_OUT: begin
          ctl.src = BUS_ACC; ctl.out_ld = 1'b1; ctl.step_clr = 1'b1;
        end
        OPC_HALT: ctl.halt = 1'b1;
        OPC_RET: begin
          if (s == 2) ctl.mar_ld = 1'b1;  // nothing drives: bus reads 0
          else begin
            ctl.src = BUS_RAM; ctl.pc_ld = 1'b1; ctl.data_seg = 1'b1; ctl.step_clr = 1'b1;
          end
        end
        default: begin
          // All remaining classes start by addressing the operand byte.
          if (s == 2) begin
            ctl.src = BUS_PC; ctl.mar_ld = 1'b1;
          end else begin
            case (cls)
              OPC_LDI_ACC: begin
                ctl.src = BUS_RAM; ctl.acc_ld = 1'b1; ctl.pc_inc = 1'b1; ctl.step_clr = 1'b1;
              end
              OPC_JMP: begin
                ctl.src = BUS_RAM; ctl.pc_ld = 1'b1; ctl.step_clr = 1'b1;
              end
              OPC_LD_ACC: begin
                if (s == 3) begin
                  ctl.src = BUS_RAM; ctl.mar_ld = 1'b1; ctl.pc_inc = 1'b1;
                end else begin
                  ctl.src = BUS_RAM; ctl.acc_ld = 1'b1; ctl.data_seg = 1'b1; ctl.step_clr = 1'b1;
                end
              end
              OPC_LD_SLOT: begin
                case (s)
                  3: begin ctl.src = BUS_RAM; ctl.mar_ld = 1'b1; ctl.pc_inc = 1'b1; end
                  4: begin ctl.src = BUS_RAM; ctl.tmp_ld = 1'b1; ctl.data_seg = 1'b1; end
                  5: begin ctl.src = BUS_SLOT; ctl.mar_ld = 1'b1; end
                  default: begin
                    ctl.src = BUS_TEMP; ctl.ram_wr = 1'b1; ctl.data_seg = 1'b1; ctl.step_clr = 1'b1;
                  end
                endcase
              end
              OPC_CALL: begin
                case (s)
                  3: begin ctl.src = BUS_RAM; ctl.tmp_ld = 1'b1; ctl.pc_inc = 1'b1; end
                  4: ctl.mar_ld = 1'b1;  // idle bus clears the address register
                  5: begin ctl.src = BUS_PC; ctl.ram_wr = 1'b1; ctl.data_seg = 1'b1; end
                  default: begin
                    ctl.src = BUS_TEMP; ctl.pc_ld = 1'b1; ctl.step_clr = 1'b1;
                  end
                endcase
              end
              OPC_LDI_SLOT: begin
                case (s)
                  3: begin ctl.src = BUS_RAM; ctl.tmp_ld = 1'b1; ctl.pc_inc = 1'b1; end
                  4: begin ctl.src = BUS_SLOT; ctl.mar_ld = 1'b1; end
                  default: begin
                    ctl.src = BUS_TEMP; ctl.ram_wr = 1'b1; ctl.data_seg = 1'b1; ctl.step_clr = 1'b1;
                  end
                endcase
              end
              default: ctl.step_clr = 1'b1;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/seg_cpu_ram.sv
module seg_cpu_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/seg_cpu_regs.sv
module seg_cpu_regs
  import seg_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] bus,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] mar,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] out_q,
  output logic              out_pulse
);

  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] tmp;

  always_comb begin
    case (ctl.src)
      BUS_RAM:  bus = ram_rdata;
      BUS_PC:   bus = pc;
      BUS_ACC:  bus = acc;
      BUS_TEMP: bus = tmp;
      BUS_SLOT: bus = {{(DATA_W-SLOT_W){1'b0}}, ir[SLOT_W-1:0]};
      default:  bus = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; mar <= '0; ir <= '0; acc <= '0; tmp <= '0;
      out_q <= '0; out_pulse <= 1'b0;
    end else if (hold) begin
      pc <= '0; mar <= '0; ir <= '0; acc <= '0; tmp <= '0;
      out_q <= '0; out_pulse <= 1'b0;
    end else begin
      if (ctl.mar_ld) mar <= bus;
      if (ctl.ir_ld)  ir  <= bus;
      if (ctl.acc_ld) acc <= bus;
      if (ctl.tmp_ld) tmp <= bus;
      if (ctl.pc_ld)       pc <= bus;
      else if (ctl.pc_inc) pc <= pc + DATA_W'(1);
      if (ctl.out_ld) out_q <= acc;
      out_pulse <= ctl.out_ld;
    end
  end

endmodule

// File: rtl/seg_cpu.sv
module seg_cpu
  import seg_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STEP_W = 3,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              load_we,
  input  logic [DATA_W:0]   load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              halted
);

  localparam int ADDR_W = DATA_W + 1;

  logic [STEP_W-1:0] step;
  ctl_t              ctl_raw;
  ctl_t              ctl;
  logic [DATA_W-1:0] bus, pc, mar, ir, ram_rdata;
  logic [ADDR_W-1:0] ram_addr;
  logic              ram_we;
  logic [DATA_W-1:0] ram_wdata;

  // Named events for the checker.
  logic ev_fetch, ev_pc_load, ev_data_seg, ev_pc_on_bus;

  seg_cpu_useq #(.STEP_W(STEP_W)) u_useq (
    .opcode (ir),
    .step   (step),
    .ctl    (ctl_raw)
  );

  // A halted or loading core issues no microoperations.
  assign ctl = (halted || load_en) ? '0 : ctl_raw;

  seg_cpu_regs #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (load_en),
    .ctl       (ctl),
    .ram_rdata (ram_rdata),
    .bus       (bus),
    .pc        (pc),
    .mar       (mar),
    .ir        (ir),
    .out_q     (out_data),
    .out_pulse (out_valid)
  );

  assign ram_addr  = load_en ? load_addr : seg_join(ctl.data_seg, mar);
  assign ram_we    = load_en ? load_we : ctl.ram_wr;
  assign ram_wdata = load_en ? load_data : bus;

  seg_cpu_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= '0;
      halted <= 1'b0;
    end else if (load_en) begin
      step   <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (ctl.halt) halted <= 1'b1;
      else if (ctl.step_clr) step <= '0;
      else step <= step + STEP_W'(1);
    end
  end

  assign ev_fetch     = ctl.ir_ld;
  assign ev_pc_load   = ctl.pc_ld;
  assign ev_data_seg  = ctl.data_seg;
  assign ev_pc_on_bus = (ctl.src == BUS_PC);

endmodule

// File: rtl/seg_cpu_chk.sv
module seg_cpu_chk #(
  parameter int ADDR_W = 9,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_en,
  input logic              halted,
  input logic              out_valid,
  input logic [STEP_W-1:0] step,
  input logic [ADDR_W-2:0] pc,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ev_fetch,
  input logic              ev_pc_load,
  input logic              ev_data_seg,
  input logic              ev_pc_on_bus
);

  localparam logic [ADDR_W-1:0] LINK_ADDR = {1'b1, {(ADDR_W-1){1'b0}}};

  AST_FETCH_IN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |-> !ram_addr[ADDR_W-1]); // R2

  AST_JUMP_FROM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pc_load && !ev_data_seg) |-> !ram_addr[ADDR_W-1]); // R2

  AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !load_en) |-> ram_addr[ADDR_W-1]); // R3

  AST_CALL_LINK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ev_pc_on_bus) |-> (ram_addr == LINK_ADDR)); // R8

  AST_RET_LINK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pc_load && ev_data_seg) |-> (ram_addr == LINK_ADDR)); // R9

  AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R4

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !load_en) |=> (load_en || (halted && $stable(pc) && $stable(step)))); // R11

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step) <= 6); // R12

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (!halted && !out_valid)); // R1

endmodule

bind seg_cpu seg_cpu_chk #(.ADDR_W(DATA_W + 1), .STEP_W(STEP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_en      (load_en),
  .halted       (halted),
  .out_valid    (out_valid),
  .step         (step),
  .pc           (pc),
  .ram_we       (ram_we),
  .ram_addr     (ram_addr),
  .ev_fetch     (ev_fetch),
  .ev_pc_load   (ev_pc_load),
  .ev_data_seg  (ev_data_seg),
  .ev_pc_on_bus (ev_pc_on_bus)
);

// File: tb/test_seg_cpu.sv
module test_seg_cpu;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 1'b1;
  logic       load_we = 1'b0;
  logic [8:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic [7:0] out_data;
  logic       out_valid;
  logic       halted;

  int errors = 0;
  int checks = 0;
  int gcyc = 0;
  logic [7:0] img [512];
  int outs [16];
  int out_cyc [16];
  int n_outs;
  int halt_cyc;

  always #2.5 clk = ~clk;

  seg_cpu i_seg_cpu (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_we(load_we),
    .load_addr(load_addr), .load_data(load_data),
    .out_data(out_data), .out_valid(out_valid), .halted(halted)
  );

  initial begin
    forever begin
      @(posedge clk);
      gcyc++;
      if (gcyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=150000 cycles", gcyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Code segment full of halts, data segment cleared.
  task automatic fresh();
    for (int i = 0; i < 512; i++) img[i] = (i < 256) ? 8'h0F : 8'h00;
  endtask

  task automatic load_run();
    @(negedge clk);
    load_en = 1'b1;
    for (int i = 0; i < 512; i++) begin
      load_we = 1'b1; load_addr = 9'(i); load_data = img[i];
      @(negedge clk);
    end
    load_we = 1'b0;
    chk(!halted && !out_valid, "R1 quiet while loading", int'({halted, out_valid}), 0);
    load_en = 1'b0;
    n_outs = 0; halt_cyc = -1;
    for (int c = 1; c <= 400; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (out_valid && n_outs < 16) begin
        outs[n_outs] = int'(out_data); out_cyc[n_outs] = c; n_outs++;
      end
      if (halted) begin halt_cyc = c; break; end
    end
  endtask

  initial begin
    int vals [5] = '{0, 1, 42, 128, 255};
    int offs [3] = '{1, 8'h55, 8'hFF};

    repeat (3) @(negedge clk);
    chk(halted == 1'b0, "R1 reset halted", int'(halted), 0);
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    chk(out_data == 8'h00, "R1 reset out_data", int'(out_data), 0);
    rst_n = 1'b1;

    // R4/R11/R12: immediate to accumulator, output, halt.
    foreach (vals[k]) begin
      fresh();
      img[0] = 8'h06; img[1] = 8'(vals[k]); img[2] = 8'h0E; img[3] = 8'h0F;
      load_run();
      chk(n_outs == 1, "R4 output count", n_outs, 1);
      chk(outs[0] == vals[k], "R4 output value", outs[0], vals[k]);
      chk(out_cyc[0] == 7, "R12 output cycle 4+3", out_cyc[0], 7);
      chk(halt_cyc == 10, "R11 halt cycle", halt_cyc, 10);
    end
    repeat (10) begin
      @(negedge clk);
      chk(halted && !out_valid, "R11 halted stays silent", int'({halted, out_valid}), 2);
    end

    // R5/R3: load accumulator from data segment; code byte at same offset differs.
    foreach (offs[k]) begin
      int d;
      d = (offs[k] ^ 8'hA5) & 255;
      fresh();
      img[256 + offs[k]] = 8'(d);
      if (offs[k] > 3) img[offs[k]] = ~8'(d);
      img[0] = 8'h08; img[1] = 8'(offs[k]); img[2] = 8'h0E; img[3] = 8'h0F;
      load_run();
      chk(n_outs == 1 && outs[0] == d, "R5 R3 data load", outs[0], d);
      chk(out_cyc[0] == 8, "R12 output cycle 5+3", out_cyc[0], 8);
    end

    // R6: immediate into every register slot, read back through the data segment.
    for (int r = 1; r <= 7; r++) begin
      int v;
      v = (r * 29 + 3) & 255;
      fresh();
      img[0] = 8'(8'h10 | r); img[1] = 8'(v);
      img[2] = 8'h08; img[3] = 8'(r); img[4] = 8'h0E; img[5] = 8'h0F;
      load_run();
      chk(n_outs == 1 && outs[0] == v, "R6 slot immediate", outs[0], v);
      chk(out_cyc[0] == 14, "R12 output cycle 6+5+3", out_cyc[0], 14);
    end

    // R7: copy data byte 0x40 into slots 3..5.
    for (int r = 3; r <= 5; r++) begin
      int d;
      d = (r * 50 + 7) & 255;
      fresh();
      img[256 + 8'h40] = 8'(d);
      img[8'h40] = 8'h00;
      img[0] = 8'(8'h08 | r); img[1] = 8'h40;
      img[2] = 8'h08; img[3] = 8'(r); img[4] = 8'h0E; img[5] = 8'h0F;
      load_run();
      chk(n_outs == 1 && outs[0] == d, "R7 slot copy", outs[0], d);
      chk(out_cyc[0] == 15, "R12 output cycle 7+5+3", out_cyc[0], 15);
    end

    // R8/R9: call a subroutine that outputs 42, return, output 7, then the saved link.
    fresh();
    img[0] = 8'h09; img[1] = 8'h20;
    img[2] = 8'h06; img[3] = 8'h07; img[4] = 8'h0E;
    img[5] = 8'h08; img[6] = 8'h00; img[7] = 8'h0E; img[8] = 8'h0F;
    img[8'h20] = 8'h06; img[8'h21] = 8'h2A; img[8'h22] = 8'h0E; img[8'h23] = 8'h0A;
    load_run();
    chk(n_outs == 3, "R8 output count", n_outs, 3);
    chk(outs[0] == 42, "R8 subroutine output", outs[0], 42);
    chk(outs[1] == 7, "R9 resumed after call", outs[1], 7);
    chk(outs[2] == 2, "R8 link byte holds return address", outs[2], 2);
    chk(out_cyc[0] == 14, "R12 call 7+4+3", out_cyc[0], 14);
    chk(out_cyc[2] == 33, "R12 ret path timing", out_cyc[2], 33);
    chk(halt_cyc == 36, "R11 halt after return", halt_cyc, 36);

    // R10/R2: jump into code 0x40; a decoy program sits at data 0x40.
    fresh();
    img[0] = 8'h01; img[1] = 8'h40;
    img[2] = 8'h06; img[3] = 8'h11; img[4] = 8'h0E; img[5] = 8'h0F;
    img[8'h40] = 8'h06; img[8'h41] = 8'h33; img[8'h42] = 8'h0E; img[8'h43] = 8'h0F;
    img[256 + 8'h40] = 8'h06; img[256 + 8'h41] = 8'h44;
    img[256 + 8'h42] = 8'h0E; img[256 + 8'h43] = 8'h0F;
    load_run();
    chk(n_outs == 1 && outs[0] == 8'h33, "R10 R2 jump target in code", outs[0], 8'h33);
    chk(out_cyc[0] == 11, "R12 jump 4+4+3", out_cyc[0], 11);

    // Undefined opcode acts as a 3-cycle no-op.
    fresh();
    img[0] = 8'h77; img[1] = 8'h06; img[2] = 8'h05; img[3] = 8'h0E; img[4] = 8'h0F;
    load_run();
    chk(n_outs == 1 && outs[0] == 5, "R12 no-op then load", outs[0], 5);
    chk(out_cyc[0] == 10, "R12 no-op 3+4+3", out_cyc[0], 10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule